// File: doc/BRIEF.md
# Staged Delay Tap Register Bank

This block holds the tap settings for the programmable delay elements of a two-lane DDR memory PHY. Each data lane has output delays for its eight data bits, its strobe and its mask, and input delays for its eight data bits and its strobe. A further set of output delays serves the command and address pins, and one register holds the clock phase. Software writes one value per cycle through a plain address/data write port. Each write lands in a shadow copy. A write to a separate apply address takes one snapshot of every shadow value and loads it into the active copy, which drives the delay elements.

The phase has its own handshake. After an apply, the requested phase becomes the target. The applied phase then walks toward that target by one count every `STEP_CYC` cycles. A status word reports the applied phase together with a ready flag. Software polls the status word until the flag is set and the phase field equals the value it requested.

Top module: `dly_bank_top`

## Requirements
- R1: When reset is active (asynchronous, active low), every shadow and active delay takes its group default: `ODLY_RST` for lane outputs, `IDLY_RST` for lane inputs and `CA_RST` for command/address pins. The applied and target phase both become `PHASE_RST`, and ready is 1.
- R2: A write to any delay or phase register changes only the shadow copy. No active output and no status bit changes until an apply.
- R3: A write to the apply address (`N_LANE*32 + N_CA + 1`, 0x61 by default) accepts any data value. On that same clock edge it copies every shadow value to the active outputs, so all outputs change together and are visible after that edge.
- R4: Lane L output delays sit at addresses `L*32 + k`, with k = 0..7 for the data bits, k = 8 for the strobe and k = 9 for the mask. Slot k of lane L appears at `lane_odly_o[(L*10+k)*8 +: 8]`. Only the low 8 bits of the write data are kept.
- R5: Lane L input delays sit at addresses `L*32 + 16 + k`, with k = 0..7 for the data bits and k = 8 for the strobe. Slot k of lane L appears at `lane_idly_o[(L*9+k)*8 +: 8]`.
- R6: The command/address delays sit at the consecutive addresses `N_LANE*32 + k` (0x40..0x5F by default). Pin k appears at `ca_odly_o[k*8 +: 8]`.
- R7: The phase register at `N_LANE*32 + N_CA` (0x60) keeps only the low `PHASE_W` bits of the write data. An apply copies it to the target phase.
- R8: Writes to addresses outside the map are ignored and change no shadow value. Examples of such addresses are lane offsets 10..15 and 25..31, and addresses 0x62 and above.
- R9: Ready is 0 whenever the applied phase differs from the target phase. The applied phase moves by exactly one count toward the target `STEP_CYC` cycles after an apply, and again every `STEP_CYC` cycles after that. Ready returns to 1 on the edge where the applied phase reaches the target.
- R10: An apply whose phase equals the current applied phase leaves ready at 1 and leaves the phase unchanged.
- R11: `status_o[7:0]` is the applied phase, zero-extended. `status_o[8]` is ready. `status_o[15:9]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Write data |
| lane_odly_o | output | N_LANE*(N_DQ+2)*DLY_W | Active output delays of the data lanes |
| lane_idly_o | output | N_LANE*(N_DQ+1)*DLY_W | Active input delays of the data lanes |
| ca_odly_o | output | N_CA*DLY_W | Active command/address output delays |
| phase_o | output | PHASE_W | Applied clock phase |
| status_o | output | 16 | Phase field and ready flag |

## Verification
A corrupted shadow value stays hidden until the next apply. From the edge after that apply onward it shows on exactly one output slice, so the bench compares every slice against its own address-indexed model after every apply. A wrong address decode shows up in the same way, as a value in the wrong slice or a lost write. Active values that move early are caught by a full compare after each staged write. A fault in the phase tracker shows in the status word within `STEP_CYC` cycles, as an early or late step or a wrong ready level, because the phase field and the ready flag are checked on every cycle of each walk.

// File: rtl/dly_bank_pkg.sv
package dly_bank_pkg;
  localparam int LANE_STRIDE = 32;
  localparam int ODLY_OFS    = 0;
  localparam int IDLY_OFS    = 16;

  localparam int KIND_ODLY = 0;
  localparam int KIND_IDLY = 1;
  localparam int KIND_CA   = 2;

  function automatic int slot_count(int n_lane, int n_dq, int n_ca);
    return n_lane * (2 * n_dq + 3) + n_ca;
  endfunction

  function automatic int ca_base(int n_lane);
    return n_lane * LANE_STRIDE;
  endfunction

  function automatic int phase_addr(int n_lane, int n_ca);
    return ca_base(n_lane) + n_ca;
  endfunction

  function automatic int apply_addr(int n_lane, int n_ca);
    return ca_base(n_lane) + n_ca + 1;
  endfunction

  // flat slot order: lane outputs, lane inputs, command/address
  function automatic int slot_kind(int idx, int n_lane, int n_dq);
    if (idx < n_lane * (n_dq + 2)) return KIND_ODLY;
    if (idx < n_lane * (2 * n_dq + 3)) return KIND_IDLY;
    return KIND_CA;
  endfunction

  function automatic int slot_addr(int idx, int n_lane, int n_dq);
    int r;
    int no;
    int ni;
    no = n_dq + 2;
    ni = n_dq + 1;
    r  = idx;
    if (r < n_lane * no) return (r / no) * LANE_STRIDE + ODLY_OFS + (r % no);
    r = r - n_lane * no;
    if (r < n_lane * ni) return (r / ni) * LANE_STRIDE + IDLY_OFS + (r % ni);
    r = r - n_lane * ni;
    return ca_base(n_lane) + r;
  endfunction
endpackage

// File: rtl/dly_bank_decode.sv
module dly_bank_decode
  import dly_bank_pkg::*;
#(
  parameter int N_LANE = 2,
  parameter int N_DQ   = 8,
  parameter int N_CA   = 32,
  parameter int ADDR_W = 8,
  localparam int NSLOT = slot_count(N_LANE, N_DQ, N_CA)
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NSLOT-1:0]  sel_o,
  output logic              phase_sel_o,
  output logic              apply_o
);
  localparam logic [ADDR_W-1:0] PH_A = ADDR_W'(phase_addr(N_LANE, N_CA));
  localparam logic [ADDR_W-1:0] AP_A = ADDR_W'(apply_addr(N_LANE, N_CA));

  for (genvar i = 0; i < NSLOT; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(slot_addr(i, N_LANE, N_DQ));
    assign sel_o[i] = wr_en_i && (addr_i == SA);
  end

  assign phase_sel_o = wr_en_i && (addr_i == PH_A);
  assign apply_o     = wr_en_i && (addr_i == AP_A);
endmodule

// File: rtl/dly_bank_store.sv
module dly_bank_store
  import dly_bank_pkg::*;
#(
  parameter int N_LANE   = 2,
  parameter int N_DQ     = 8,
  parameter int N_CA     = 32,
  parameter int DLY_W    = 8,
  parameter int ODLY_RST = 8'h30,
  parameter int IDLY_RST = 8'h40,
  parameter int CA_RST   = 8'h50,
  localparam int NSLOT   = slot_count(N_LANE, N_DQ, N_CA)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSLOT-1:0]       sel_i,
  input  logic [DLY_W-1:0]       data_i,
  input  logic                   apply_i,
  output logic [NSLOT*DLY_W-1:0] active_o
);
  logic [DLY_W-1:0] shadow_q [NSLOT];
  logic [DLY_W-1:0] active_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int KIND = slot_kind(i, N_LANE, N_DQ);
    localparam logic [DLY_W-1:0] RV = (KIND == KIND_ODLY) ? DLY_W'(ODLY_RST) :
                                      (KIND == KIND_IDLY) ? DLY_W'(IDLY_RST) :
                                                            DLY_W'(CA_RST);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i] <= RV;
        active_q[i] <= RV;
      end else begin
        if (sel_i[i]) shadow_q[i] <= data_i;
        if (apply_i)  active_q[i] <= shadow_q[i];
      end
    end
    assign active_o[i*DLY_W +: DLY_W] = active_q[i];

    assert_apply_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      apply_i |=> active_q[i] == $past(shadow_q[i]));
  end

  assert_active_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(active_o));
endmodule

// File: rtl/dly_phase_track.sv
module dly_phase_track #(
  parameter int PHASE_W   = 8,
  parameter int STEP_CYC  = 4,
  parameter int PHASE_RST = 8'h10,
  localparam int CNT_W    = $clog2(STEP_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] data_i,
  input  logic               apply_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               ready_o
);
  localparam logic [PHASE_W-1:0] RV   = PHASE_W'(PHASE_RST);
  localparam logic [CNT_W-1:0]   LAST = CNT_W'(STEP_CYC - 1);

  logic [PHASE_W-1:0] shadow_q, tgt_q, cur_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RV;
      tgt_q    <= RV;
      cur_q    <= RV;
      cnt_q    <= '0;
    end else begin
      if (load_i) shadow_q <= data_i;
      if (apply_i) begin
        tgt_q <= shadow_q;
        cnt_q <= '0;
      end else if (cur_q != tgt_q) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          cur_q <= (cur_q < tgt_q) ? cur_q + 1'b1 : cur_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = cur_q;
  assign ready_o = (cur_q == tgt_q);

  assert_unit_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cur_q == $past(cur_q)) ||
             (cur_q == PHASE_W'($past(cur_q) + 1'b1)) ||
             (cur_q == PHASE_W'($past(cur_q) - 1'b1)));

  assert_ready_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !apply_i) |=> $stable(cur_q) && ready_o);
endmodule

// File: rtl/dly_bank_top.sv
module dly_bank_top
  import dly_bank_pkg::*;
#(
  parameter int N_LANE    = 2,
  parameter int N_DQ      = 8,
  parameter int N_CA      = 32,
  parameter int DLY_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PHASE_W   = 8,
  parameter int STEP_CYC  = 4,
  parameter int ODLY_RST  = 8'h30,
  parameter int IDLY_RST  = 8'h40,
  parameter int CA_RST    = 8'h50,
  parameter int PHASE_RST = 8'h10,
  localparam int NSLOT    = slot_count(N_LANE, N_DQ, N_CA),
  localparam int ODLY_B   = N_LANE * (N_DQ + 2) * DLY_W,
  localparam int IDLY_B   = N_LANE * (N_DQ + 1) * DLY_W,
  localparam int CA_B     = N_CA * DLY_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [ODLY_B-1:0]  lane_odly_o,
  output logic [IDLY_B-1:0]  lane_idly_o,
  output logic [CA_B-1:0]    ca_odly_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [15:0]        status_o
);
  logic [NSLOT-1:0]       sel;
  logic                   phase_sel, apply;
  logic [NSLOT*DLY_W-1:0] active;
  logic                   ready;
  logic [7:0]             phase8;
  logic                   unused_data;

  assign unused_data = ^wr_data_i;

  dly_bank_decode #(
    .N_LANE(N_LANE), .N_DQ(N_DQ), .N_CA(N_CA), .ADDR_W(ADDR_W)
  ) u_decode (
    .wr_en_i    (wr_en_i),
    .addr_i     (wr_addr_i),
    .sel_o      (sel),
    .phase_sel_o(phase_sel),
    .apply_o    (apply)
  );

  dly_bank_store #(
    .N_LANE(N_LANE), .N_DQ(N_DQ), .N_CA(N_CA), .DLY_W(DLY_W),
    .ODLY_RST(ODLY_RST), .IDLY_RST(IDLY_RST), .CA_RST(CA_RST)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel),
    .data_i  (wr_data_i[DLY_W-1:0]),
    .apply_i (apply),
    .active_o(active)
  );

  dly_phase_track #(
    .PHASE_W(PHASE_W), .STEP_CYC(STEP_CYC), .PHASE_RST(PHASE_RST)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (phase_sel),
    .data_i (wr_data_i[PHASE_W-1:0]),
    .apply_i(apply),
    .phase_o(phase_o),
    .ready_o(ready)
  );

  assign lane_odly_o = active[ODLY_B-1:0];
  assign lane_idly_o = active[ODLY_B +: IDLY_B];
  assign ca_odly_o   = active[ODLY_B+IDLY_B +: CA_B];

  assign phase8   = 8'(phase_o);
  assign status_o = {7'd0, ready, phase8};

  assert_one_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel, phase_sel, apply}));

  assert_no_early_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_sel && ready) |=> ready);
endmodule

// File: tb/dly_bank_top_bench.sv
`timescale 1ns/1ps
module dly_bank_top_bench;
  localparam int STEP = 4;
  localparam int OR_V = 8'h30, IR_V = 8'h40, CR_V = 8'h50, PR_V = 8'h10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [159:0] lane_odly_o;
  logic [143:0] lane_idly_o;
  logic [255:0] ca_odly_o;
  logic [7:0]   phase_o;
  logic [15:0]  status_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_sh  [256];
  logic [7:0] m_act [256];

  always #4 clk_i = ~clk_i;

  dly_bank_top #(
    .N_LANE(2), .N_DQ(8), .N_CA(32), .DLY_W(8), .ADDR_W(8), .DATA_W(16),
    .PHASE_W(8), .STEP_CYC(STEP), .ODLY_RST(OR_V), .IDLY_RST(IR_V),
    .CA_RST(CR_V), .PHASE_RST(PR_V)
  ) u_dly_bank_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .lane_odly_o(lane_odly_o), .lane_idly_o(lane_idly_o),
    .ca_odly_o(ca_odly_o), .phase_o(phase_o), .status_o(status_o)
  );

  // {addr, data}
  localparam logic [23:0] VEC [12] = '{
    {8'h00, 16'h0001}, {8'h08, 16'h0108}, {8'h09, 16'h0009}, {8'h0A, 16'h00EE},
    {8'h10, 16'h0021}, {8'h18, 16'h0028}, {8'h19, 16'h00EE}, {8'h29, 16'h0039},
    {8'h38, 16'h0048}, {8'h40, 16'h0061}, {8'h5F, 16'h007F}, {8'h62, 16'h00EE}
  };

  function automatic int kind_of(int a);
    int o;
    if (a >= 8'h40 && a < 8'h60) return 3;
    if (a >= 8'h40) return 0;
    o = a % 32;
    if (o < 10) return 1;
    if (o >= 16 && o < 25) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] def_of(int a);
    case (kind_of(a))
      1: return 8'(OR_V);
      2: return 8'(IR_V);
      3: return 8'(CR_V);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) begin
      m_sh[a]  = def_of(a);
      m_act[a] = def_of(a);
    end
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int l = 0; l < 2; l++) begin
      for (int k = 0; k < 10; k++)
        check($sformatf("%s/R4 lane%0d out%0d", tag, l, k),
              lane_odly_o[(l*10+k)*8 +: 8], m_act[l*32+k]);
      for (int k = 0; k < 9; k++)
        check($sformatf("%s/R5 lane%0d in%0d", tag, l, k),
              lane_idly_o[(l*9+k)*8 +: 8], m_act[l*32+16+k]);
    end
    for (int k = 0; k < 32; k++)
      check($sformatf("%s/R6 ca%0d", tag, k), ca_odly_o[k*8 +: 8], m_act[64+k]);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (kind_of(int'(a)) != 0) m_sh[a] = d[7:0];
  endtask

  task automatic apply(logic [15:0] d);
    wr(8'h61, d);
    for (int a = 0; a < 256; a++) m_act[a] = m_sh[a];
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    check("R1 status at reset", status_o, 16'h0110);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // staged writes from the table; nothing active may move
    for (int v = 0; v < 12; v++) begin
      wr(VEC[v][23:16], VEC[v][15:0]);
      check_all($sformatf("R2 R8 vec%0d", v));
      check("R2 status", status_o, 16'h0110);
    end
    apply(16'hA5C3);
    check_all("R3 R8");

    // phase walk up: 0x10 -> 0x13, upper data bits masked
    wr(8'h60, 16'hAB13);
    check("R2 R7 status before apply", status_o, 16'h0110);
    apply(16'h0000);
    for (int c = 0; c < 14; c++) begin
      int ph;
      ph = PR_V + ((c / STEP) > 3 ? 3 : (c / STEP));
      check($sformatf("R9 R7 R11 up c=%0d", c), status_o,
            ((c >= 3 * STEP) ? 16'h0100 : 16'h0000) | ph);
      check("R9 phase_o up", phase_o, ph);
      @(negedge clk_i);
    end

    // walk down 0x13 -> 0x11
    wr(8'h60, 16'h0011);
    apply(16'hFFFF);
    for (int c = 0; c < 10; c++) begin
      int ph;
      ph = 8'h13 - ((c / STEP) > 2 ? 2 : (c / STEP));
      check($sformatf("R9 R11 down c=%0d", c), status_o,
            ((c >= 2 * STEP) ? 16'h0100 : 16'h0000) | ph);
      @(negedge clk_i);
    end

    // apply with unchanged phase keeps ready
    wr(8'h60, 16'h0011);
    apply(16'h0001);
    for (int c = 0; c < 3; c++) begin
      check("R10 same phase", status_o, 16'h0111);
      @(negedge clk_i);
    end

    // second pattern: every slot of lane 1 outputs and some CA
    for (int k = 0; k < 10; k++) wr(8'(32 + k), 16'(8'h80 + k));
    for (int k = 0; k < 32; k += 5) wr(8'(64 + k), 16'(8'hC0 + k));
    check_all("R2 pattern2");
    apply(16'h1234);
    check_all("R3 pattern2");

    // asynchronous reset restores shadow and active
    wr(8'h00, 16'h00AA);
    wr(8'h60, 16'h0020);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    model_reset();
    check_all("R1 async");
    check("R1 status async", status_o, 16'h0110);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(16'h0000);
    check_all("R1 shadow reset");
    check("R1 R10 phase after reset apply", status_o, 16'h0110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule